// File: doc/BRIEF.md
# Transmit Descriptor DMA Engine

This block walks a linked chain of transmit descriptors held in memory and turns each one into a byte stream for a downstream transmitter. Each descriptor occupies eight consecutive 32-bit little-endian words. Word 0 holds the buffer start address and word 2 the address of the next descriptor. Bit 31 of word 3 marks the final descriptor. Word 4 carries the byte count in bits 15:0, and word 5 holds the control and status bits. Words 1, 6 and 7 are never read. For every descriptor the engine reads the control word first. It then collects the pointers and the count, fetches the buffer one aligned word at a time and streams the bytes with frame markers. Once the final byte has been taken downstream, it writes a completion status back over the control word.

Software sets the start point with a small register write port. It first writes the descriptor address to the pointer register, then writes the start register with bit 31 set. Fetching proceeds only while the control register has both its go bit and its queue-0 enable set. A descriptor that the engine does not own stops the queue at once. So does the end of the chain. A stop flag reports either case.

Top module: `tx_desc_dma`

## Requirements
- R1: The register port is selected by `cfg_sel`: 0 is the descriptor pointer, 1 is start, 2 is control. Writing start with bit 31 set arms the engine at the pointer value. Its first memory access is a read of pointer+20, the control word. After reset no request or beat is issued and `q_stopped` is low.
- R2: While the control register does not have both bit 15 (go) and bit 0 (queue enable) set, an idle engine issues no memory request.
- R3: If bit 31 (owner) of a fetched control word is clear, the engine reads no buffer word for that descriptor and does not write it back. It goes idle and raises `q_stopped`.
- R4: Exactly the byte count (word 4, bits 15:0) is streamed. Bytes come in ascending address order from the buffer address in word 0, which may have any byte alignment. The byte at address a is bits 8*(a mod 4)+7 down to 8*(a mod 4) of the memory word at a rounded down to a multiple of 4.
- R5: `tx_sof` is high on the first beat only when control bit 1 is set. `tx_eof` is high on the last beat only when control bit 0 is set. A zero count produces no beats.
- R6: Write-back is a single write to descriptor+20, issued only after the last byte has been accepted. The written value is the fetched control word with bit 31 cleared and four status bits rewritten: bit 26 = `tx_err[0]` (retry limit), bit 25 = `tx_err[1]` (underrun), bit 24 = `tx_err[2]` (late collision), and bit 30 (success) = none of them. All other bits are kept.
- R7: After write-back the engine moves to the address in word 2. If bit 31 of word 3 was set, it instead goes idle, raises `q_stopped` and makes no further request.
- R8: A memory request keeps its address, direction and write data unchanged until `mem_ack`. Read data is taken in the cycle of `mem_ack`.
- R9: While `tx_valid` is high and `tx_ready` is low, the data and markers stay unchanged.
- R10: `q_stopped` stays set while the engine is idle and clears when a new start is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: pointer, start, control |
| cfg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data (status word) |
| mem_ack | input | 1 | Memory request completed; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_err | input | 3 | Frame outcome: retry limit, underrun, late collision |
| q_stopped | output | 1 | Queue has stopped |

## Verification
The bench uses the default widths (32-bit addresses, 16-bit byte count) with a 1 KiB memory model. The memory model has varying acknowledge latency, and the stream sink stalls every third cycle. Forty descriptors sweep all four buffer byte offsets against every count from zero to nine. This covers every starting lane, every word crossing, empty frames and mid-word ends, with marker and status-bit combinations varied per descriptor. Separate runs cover the control gating, a descriptor that is not owned in the middle of a chain, and restart after stop.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;
  // byte offsets of the descriptor words the engine touches
  localparam int OFS_BUF   = 0;
  localparam int OFS_NXT   = 8;
  localparam int OFS_NXTHI = 12;
  localparam int OFS_LEN   = 16;
  localparam int OFS_CTRL  = 20;

  // control / status word bits
  localparam int B_OWN   = 31;
  localparam int B_OK    = 30;
  localparam int B_RETRY = 26;
  localparam int B_UNDER = 25;
  localparam int B_LATE  = 24;
  localparam int B_SOF   = 1;
  localparam int B_EOF   = 0;
  localparam int B_LAST  = 31;

  // register port
  localparam logic [1:0] SEL_PTR   = 2'd0;
  localparam logic [1:0] SEL_START = 2'd1;
  localparam logic [1:0] SEL_CTL   = 2'd2;
  localparam int B_VALID = 31;
  localparam int B_GO    = 15;
  localparam int B_QEN   = 0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CTRL, ST_BUF, ST_NXL, ST_NXH, ST_LEN, ST_FILL, ST_EMIT, ST_WB
  } walk_st_t;
endpackage

// File: rtl/tx_desc_regs.sv
module tx_desc_regs
  import tx_desc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [ADDR_W-1:0] ptr_lo,
  output logic              start_pls,
  output logic              run_en
);
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              go_q, go_d, qen_q, qen_d, start_q, start_d;
  logic              ptr_en, ctl_en;

  always_comb begin
    ptr_en  = cfg_we && (cfg_sel == SEL_PTR);
    ctl_en  = cfg_we && (cfg_sel == SEL_CTL);
    ptr_d   = cfg_wdata[ADDR_W-1:0];
    go_d    = cfg_wdata[B_GO];
    qen_d   = cfg_wdata[B_QEN];
    start_d = cfg_we && (cfg_sel == SEL_START) && cfg_wdata[B_VALID];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      go_q    <= 1'b0;
      qen_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      if (ctl_en) begin
        go_q  <= go_d;
        qen_q <= qen_d;
      end
      start_q <= start_d;
    end
  end

  assign ptr_lo    = ptr_q;
  assign start_pls = start_q;
  assign run_en    = go_q && qen_q;
endmodule

// File: rtl/tx_desc_wb_fmt.sv
module tx_desc_wb_fmt
  import tx_desc_pkg::*;
(
  input  logic [31:0] ctrl_word,
  input  logic [2:0]  err_word,
  output logic [31:0] wb_word
);
  always_comb begin
    wb_word          = ctrl_word;
    wb_word[B_OWN]   = 1'b0;
    wb_word[B_OK]    = (err_word == 3'b000);
    wb_word[B_RETRY] = err_word[0];
    wb_word[B_UNDER] = err_word[1];
    wb_word[B_LATE]  = err_word[2];
  end
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
  import tx_desc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_pls,
  input  logic              run_en,
  input  logic [ADDR_W-1:0] ptr_lo,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  input  logic              tx_ready,
  input  logic [2:0]        err_in,
  output logic [31:0]       ctrl_word,
  output logic [2:0]        err_word,
  output logic              q_stopped
);
  localparam int LANE_W = 2;

  walk_st_t          st_q, st_d;
  logic [ADDR_W-1:0] desc_q, desc_d, cur_q, cur_d, nxt_q, nxt_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [31:0]       ctrl_q, ctrl_d, word_q, word_d;
  logic [2:0]        err_q, err_d;
  logic              armed_q, armed_d, stop_q, stop_d;
  logic              last_q, last_d, first_q, first_d;
  logic [LANE_W-1:0] lane;
  logic              beat_go, final_beat;

  // memory request decode
  always_comb begin
    mem_req  = 1'b1;
    mem_we   = 1'b0;
    mem_addr = desc_q + ADDR_W'(OFS_CTRL);
    case (st_q)
      ST_CTRL: mem_addr = desc_q + ADDR_W'(OFS_CTRL);
      ST_BUF:  mem_addr = desc_q + ADDR_W'(OFS_BUF);
      ST_NXL:  mem_addr = desc_q + ADDR_W'(OFS_NXT);
      ST_NXH:  mem_addr = desc_q + ADDR_W'(OFS_NXTHI);
      ST_LEN:  mem_addr = desc_q + ADDR_W'(OFS_LEN);
      ST_FILL: mem_addr = {cur_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      ST_WB: begin
        mem_we   = 1'b1;
        mem_addr = desc_q + ADDR_W'(OFS_CTRL);
      end
      default: mem_req = 1'b0;
    endcase
  end

  // stream side
  always_comb begin
    lane       = cur_q[LANE_W-1:0];
    final_beat = (rem_q == LEN_W'(1));
    tx_valid   = (st_q == ST_EMIT);
    tx_data    = word_q[{lane, 3'b000} +: 8];
    tx_sof     = tx_valid && first_q && ctrl_q[B_SOF];
    tx_eof     = tx_valid && final_beat && ctrl_q[B_EOF];
    beat_go    = tx_valid && tx_ready;
  end

  // next state
  always_comb begin
    st_d    = st_q;    desc_d  = desc_q;  cur_d   = cur_q;   nxt_d  = nxt_q;
    rem_d   = rem_q;   ctrl_d  = ctrl_q;  word_d  = word_q;  err_d  = err_q;
    armed_d = armed_q; stop_d  = stop_q;  last_d  = last_q;  first_d = first_q;
    case (st_q)
      ST_IDLE: begin
        if (start_pls) begin
          desc_d  = ptr_lo;
          armed_d = 1'b1;
          stop_d  = 1'b0;
        end else if (armed_q && run_en) begin
          st_d = ST_CTRL;
        end
      end
      ST_CTRL: if (mem_ack) begin
        ctrl_d = mem_rdata;
        if (!mem_rdata[B_OWN]) begin
          st_d    = ST_IDLE;
          armed_d = 1'b0;
          stop_d  = 1'b1;
        end else begin
          st_d = ST_BUF;
        end
      end
      ST_BUF: if (mem_ack) begin
        cur_d = mem_rdata[ADDR_W-1:0];
        st_d  = ST_NXL;
      end
      ST_NXL: if (mem_ack) begin
        nxt_d = mem_rdata[ADDR_W-1:0];
        st_d  = ST_NXH;
      end
      ST_NXH: if (mem_ack) begin
        last_d = mem_rdata[B_LAST];
        st_d   = ST_LEN;
      end
      ST_LEN: if (mem_ack) begin
        rem_d   = mem_rdata[LEN_W-1:0];
        first_d = 1'b1;
        if (mem_rdata[LEN_W-1:0] == '0) begin
          st_d  = ST_WB;
          err_d = err_in;
        end else begin
          st_d = ST_FILL;
        end
      end
      ST_FILL: if (mem_ack) begin
        word_d = mem_rdata;
        st_d   = ST_EMIT;
      end
      ST_EMIT: if (beat_go) begin
        rem_d   = rem_q - LEN_W'(1);
        cur_d   = cur_q + ADDR_W'(1);
        first_d = 1'b0;
        if (final_beat) begin
          st_d  = ST_WB;
          err_d = err_in;
        end else if (&lane) begin
          st_d = ST_FILL;
        end
      end
      ST_WB: if (mem_ack) begin
        st_d = ST_IDLE;
        if (last_q) begin
          armed_d = 1'b0;
          stop_d  = 1'b1;
        end else begin
          desc_d = nxt_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      desc_q  <= '0;  cur_q  <= '0;  nxt_q  <= '0;  rem_q  <= '0;
      ctrl_q  <= '0;  word_q <= '0;  err_q  <= '0;
      armed_q <= 1'b0; stop_q <= 1'b0; last_q <= 1'b0; first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      desc_q  <= desc_d;  cur_q  <= cur_d;  nxt_q  <= nxt_d;  rem_q  <= rem_d;
      ctrl_q  <= ctrl_d;  word_q <= word_d; err_q  <= err_d;
      armed_q <= armed_d; stop_q <= stop_d; last_q <= last_d; first_q <= first_d;
    end
  end

  assign ctrl_word = ctrl_q;
  assign err_word  = err_q;
  assign q_stopped = stop_q;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)); // R9
  AST_IDLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && !run_en |=> !mem_req); // R2
endmodule

// File: rtl/tx_desc_dma.sv
module tx_desc_dma
  import tx_desc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  input  logic              tx_ready,
  input  logic [2:0]        tx_err,
  output logic              q_stopped
);
  logic [ADDR_W-1:0] ptr_lo;
  logic              start_pls, run_en;
  logic [31:0]       ctrl_word;
  logic [2:0]        err_word;

  tx_desc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ptr_lo(ptr_lo), .start_pls(start_pls), .run_en(run_en)
  );

  tx_desc_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_pls(start_pls), .run_en(run_en), .ptr_lo(ptr_lo),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .tx_ready(tx_ready), .err_in(tx_err), .ctrl_word(ctrl_word),
    .err_word(err_word), .q_stopped(q_stopped)
  );

  tx_desc_wb_fmt u_fmt (
    .ctrl_word(ctrl_word), .err_word(err_word), .wb_word(mem_wdata)
  );

  AST_WB_OWNER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[B_OWN]); // R6
  AST_WB_OK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (mem_wdata[B_OK] != (mem_wdata[B_RETRY] || mem_wdata[B_UNDER] || mem_wdata[B_LATE]))); // R6
endmodule

// File: tb/tx_desc_dma_test.sv
module tx_desc_dma_test;
  localparam int MEM_WORDS = 256;
  localparam int BUF_BASE  = 32'h200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req, mem_we;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        tx_valid, tx_sof, tx_eof;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic [2:0]  tx_err = '0;
  logic        q_stopped;

  always #4 clk = ~clk;

  tx_desc_dma uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_ready(tx_ready), .tx_err(tx_err),
    .q_stopped(q_stopped)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [MEM_WORDS];
  int          e_buf [8];
  int          e_cnt [8];
  logic        e_sof [8];
  logic        e_eof [8];
  logic [31:0] e_ctrl [8];
  int cyc = 0, lat = 0, cur_k = -1, beat_n = 0, wb_cnt = 0, req_cnt = 0;
  int own_stop = 0, post_stop_rd = 0, wk = 0;
  logic [31:0] first_rd = '0;
  logic        first_seen = 1'b0;
  logic        stall_pend = 1'b0, st_sof = 1'b0, st_eof = 1'b0;
  logic [7:0]  st_data = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] exp_wb(input int k);
    logic [31:0] w = e_ctrl[k];
    logic [2:0]  e = 3'(k % 8);
    w[31] = 1'b0; w[30] = (e == 3'd0); w[26] = e[0]; w[25] = e[1]; w[24] = e[2];
    return w;
  endfunction

  // memory model and stream sink, both act on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      mem_ack  = 1'b0;
      tx_ready = 1'b0;
    end else begin
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (lat > 0) lat--;
        else begin
          mem_ack = 1'b1;
          lat = cyc % 3;
          req_cnt++;
          if (!mem_we) begin
            mem_rdata = mem[mem_addr[9:2]];
            if (!first_seen) begin first_seen = 1'b1; first_rd = mem_addr; end
            if (own_stop != 0 && mem_addr >= BUF_BASE) post_stop_rd++;
            if (mem_addr < BUF_BASE && mem_addr[4:0] == 5'd20) begin
              cur_k = int'(mem_addr >> 5);
              beat_n = 0;
              tx_err = 3'(cur_k % 8);
              if (!mem[mem_addr[9:2]][31]) own_stop = 1;
            end
          end else begin
            wk = int'(mem_addr >> 5);
            if (wk >= 0 && wk < 8) begin
              chk(mem_addr[4:0] == 5'd20 && wk == cur_k, "R6 write-back address", mem_addr, 32'(32 * cur_k + 20));
              chk(mem_wdata == exp_wb(wk), "R6 write-back value", mem_wdata, exp_wb(wk));
              chk(beat_n == e_cnt[wk], "R4 bytes streamed per frame", 32'(beat_n), 32'(e_cnt[wk]));
            end else begin
              chk(1'b0, "R6 write-back outside descriptor area", mem_addr, 32'd0);
            end
            mem[mem_addr[9:2]] = mem_wdata;
            wb_cnt++;
          end
        end
      end
      if (stall_pend)
        chk(tx_valid && tx_data == st_data && tx_sof == st_sof && tx_eof == st_eof,
            "R9 beat held under backpressure", {23'd0, tx_valid, tx_data}, {23'd1, st_data});
      tx_ready   = (cyc % 3) != 1;
      stall_pend = tx_valid && !tx_ready;
      st_data = tx_data; st_sof = tx_sof; st_eof = tx_eof;
      if (tx_valid && tx_ready) begin
        if (cur_k >= 0 && cur_k < 8) begin
          chk(tx_data == pat(e_buf[cur_k] + beat_n), "R4 byte value", 32'(tx_data), 32'(pat(e_buf[cur_k] + beat_n)));
          chk(tx_sof == (beat_n == 0 && e_sof[cur_k]), "R5 start marker", 32'(tx_sof), 32'(beat_n == 0 && e_sof[cur_k]));
          chk(tx_eof == (beat_n == e_cnt[cur_k] - 1 && e_eof[cur_k]), "R5 end marker", 32'(tx_eof),
              32'(beat_n == e_cnt[cur_k] - 1 && e_eof[cur_k]));
        end else begin
          chk(1'b0, "R4 beat outside any frame", 32'(tx_data), 32'd0);
        end
        beat_n++;
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic build_chain(input int base, input int own_clr);
    for (int j = 0; j < 8; j++) begin
      int c = base + j;
      int ba = BUF_BASE + 32 * j + (c % 4);
      logic [31:0] cw;
      e_buf[j] = ba;
      e_cnt[j] = (c / 4) % 10;
      e_sof[j] = (c % 3) != 0;
      e_eof[j] = ((c * 7) % 5) != 2;
      cw = {(j != own_clr), 1'b0, 29'd0, 1'b0};
      cw[30] = (c % 4) == 1;
      cw[24] = (c % 5) == 0;
      cw[11:8] = 4'(c % 7);
      cw[5] = (c % 3) == 0;
      cw[4] = (c % 2) == 1;
      cw[1] = e_sof[j];
      cw[0] = e_eof[j];
      e_ctrl[j] = cw;
      mem[8*j+0] = 32'(ba);
      mem[8*j+1] = 32'hDEAD_0000 | 32'(j);
      mem[8*j+2] = 32'(32 * (j + 1));
      mem[8*j+3] = (j == 7) ? 32'h8000_0000 : 32'h0;
      mem[8*j+4] = (32'(c) << 16) | 32'(e_cnt[j]);
      mem[8*j+5] = cw;
      mem[8*j+6] = '0;
      mem[8*j+7] = '0;
    end
    cur_k = -1; wb_cnt = 0; own_stop = 0; post_stop_rd = 0;
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 20000 && !q_stopped; i++) @(negedge clk);
  endtask

  task automatic finish_run(input int frames, input string tag);
    int r;
    chk(q_stopped, {tag, " queue stop flag"}, 32'(q_stopped), 32'd1);
    chk(wb_cnt == frames, {tag, " frames completed"}, 32'(wb_cnt), 32'(frames));
    r = req_cnt;
    repeat (30) @(negedge clk);
    chk(req_cnt == r, {tag, " no request after stop"}, 32'(req_cnt - r), 32'd0);
    chk(q_stopped, "R10 flag held while idle", 32'(q_stopped), 32'd1);
  endtask

  task automatic restart(input int base, input int own_clr);
    build_chain(base, own_clr);
    cfg_write(2'd0, 32'h0);
    cfg_write(2'd1, 32'h8000_0000);
    repeat (2) @(negedge clk);
    chk(!q_stopped, "R10 flag cleared by new start", 32'(q_stopped), 32'd0);
    wait_stop();
  endtask

  initial begin
    for (int i = 0; i < MEM_WORDS; i++)
      mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
    repeat (3) @(negedge clk);
    chk(!tx_valid && !mem_req && !q_stopped, "R1 reset state", {29'd0, tx_valid, mem_req, q_stopped}, 32'd0);
    rst_n = 1'b1;
    build_chain(0, -1);
    cfg_write(2'd0, 32'h0);
    cfg_write(2'd1, 32'h8000_0000);
    repeat (20) @(negedge clk);
    chk(req_cnt == 0, "R2 no fetch with control clear", 32'(req_cnt), 32'd0);
    cfg_write(2'd2, 32'h0000_8000);
    repeat (20) @(negedge clk);
    chk(req_cnt == 0, "R2 no fetch with go only", 32'(req_cnt), 32'd0);
    cfg_write(2'd2, 32'h0000_0001);
    repeat (20) @(negedge clk);
    chk(req_cnt == 0, "R2 no fetch with enable only", 32'(req_cnt), 32'd0);
    cfg_write(2'd2, 32'h0000_8001);
    wait_stop();
    chk(first_rd == 32'h14, "R1 first fetch is control word", first_rd, 32'h14);
    finish_run(8, "R7");
    for (int b = 8; b < 40; b += 8) begin
      restart(b, -1);
      finish_run(8, "R7");
    end
    restart(0, 3);
    chk(post_stop_rd == 0, "R3 no buffer read for unowned descriptor", 32'(post_stop_rd), 32'd0);
    chk(mem[8*3+5] == e_ctrl[3], "R3 unowned descriptor left unchanged", mem[8*3+5], e_ctrl[3]);
    finish_run(3, "R3");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual=0x%08h expected=0x%08h", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule